// File: doc/BRIEF.md
# Sticky Interrupt Cause Collector with Report Mask

The block sits on the slave side of a serial link. It gathers six event sources into sticky cause bits: bus-reset completion, a NACK from a downstream device, a GPIO input change, a link communication error, a 2-wire bus timeout and a link timeout. Each source raises its bit with a single-cycle pulse. The bit then holds at 1 until software clears it.

A six-bit mask register chooses which of the set causes take part in the report. The block ORs the enabled, set causes into one interrupt flag, which is passed on to the link master.

Software reaches the block over a byte-wide register bus. Any write to the cause address clears every cause except the GPIO one, whatever data is written. The GPIO cause ignores writes. It clears only when the bus reads the separate GPIO monitor address, which is decoded here only for this side effect.

Top module: `irq_cause_mask`

## Requirements
- R1: After reset the cause register reads 0x00, the mask register reads 0x00, and `irq_out` is 0.
- R2: A pulse on `evt_pulse[i]` sets cause bit i, and the bit stays at 1 through any number of idle cycles. The bit positions are: 5 reset done, 4 NACK, 3 GPIO change, 2 communication error, 1 2-wire timeout, 0 link timeout.
- R3: Any write to the cause address (default 0x02) clears cause bits 5, 4, 2, 1 and 0, for every write data value.
- R4: Cause bit 3 (GPIO change) is left unchanged by writes to the cause address. It is cleared by a read strobe at the GPIO monitor address (default 0x41).
- R5: A read of the cause address returns {2'b00, cause}. A read of the mask address (default 0x03) returns {2'b00, mask}. A read of any other address returns 0x00, and bits 7:6 always read 0.
- R6: A write to the mask address stores write data bits 5:0. Bits 7:6 of the write data are dropped.
- R7: `irq_out` is 1 exactly when some cause bit and its mask bit are both 1.
- R8: A cause bit sets from its pulse even while its mask bit is 0.
- R9: A pulse that arrives in the same cycle as a clearing write or a clearing read leaves its cause bit at 1.
- R10: Reading the cause address or the mask address changes no cause bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| evt_pulse | input | 6 | Single-cycle event pulses, one per cause bit |
| irq_out | output | 1 | Combined interrupt flag toward the link master |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle. They also assume that every strobe and every event pulse is sampled at a single rising edge. The stimulus drives each access and each pulse for exactly one cycle and never overlaps a read with a write. Event pulses are lined up with a write or a read only in the collision cases that R9 describes. Read data is combinational, so the bench samples it in the cycle of the read strobe, before the edge that could apply a read side effect.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int CAUSE_W   = 6;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int IDX_RSTDN = 5;
  localparam int IDX_NACK  = 4;
  localparam int IDX_GPIO  = 3;
  localparam int IDX_CERR  = 2;
  localparam int IDX_WTO   = 1;
  localparam int IDX_LTO   = 0;

  typedef enum logic [1:0] {
    CLR_NONE  = 2'd0,
    CLR_WRITE = 2'd1,
    CLR_MONRD = 2'd2
  } clr_kind_e;

  function automatic clr_kind_e clr_kind_of(input int idx);
    return (idx == IDX_GPIO) ? CLR_MONRD : CLR_WRITE;
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_agg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CAUSE_ADDR  = 8'h02,
  parameter logic [ADDR_W-1:0] MASK_ADDR   = 8'h03,
  parameter logic [ADDR_W-1:0] GPMON_ADDR  = 8'h41
) (
  input  logic               clk,
  input  logic               rst_n_i,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [CAUSE_W-1:0] cause_q,
  input  logic [CAUSE_W-1:0] mask_q,
  output logic               cause_wr_clr,
  output logic               mask_wr,
  output logic               gpmon_rd,
  output logic [DATA_W-1:0]  bus_rdata
);
  localparam int PAD_W = DATA_W - CAUSE_W;

  logic hit_cause, hit_mask, hit_gpmon;

  always_comb begin
    hit_cause    = (bus_addr == CAUSE_ADDR);
    hit_mask     = (bus_addr == MASK_ADDR);
    hit_gpmon    = (bus_addr == GPMON_ADDR);
    cause_wr_clr = bus_wr & hit_cause;
    mask_wr      = bus_wr & hit_mask;
    gpmon_rd     = bus_rd & hit_gpmon;
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_cause)     bus_rdata = {{PAD_W{1'b0}}, cause_q};
    else if (hit_mask) bus_rdata = {{PAD_W{1'b0}}, mask_q};
  end

  assert_pad_zero_R5: assert property (@(posedge clk) disable iff (!rst_n_i)
    bus_rdata[DATA_W-1:CAUSE_W] == '0);

  assert_unmapped_zero_R5: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!hit_cause && !hit_mask) |-> (bus_rdata == '0));
endmodule

// File: rtl/irq_cause_bit.sv
module irq_cause_bit
  import irq_agg_pkg::*;
#(
  parameter clr_kind_e CLR_KIND = CLR_WRITE
) (
  input  logic clk,
  input  logic rst_n_i,
  input  logic evt,
  input  logic cause_wr_clr,
  input  logic gpmon_rd,
  output logic cause_q
);
  logic clr_en;
  logic cause_d;
  logic upd_en;

  generate
    if (CLR_KIND == CLR_WRITE) begin : g_wr_clear
      assign clr_en = cause_wr_clr;
    end else if (CLR_KIND == CLR_MONRD) begin : g_rd_clear
      assign clr_en = gpmon_rd;
    end else begin : g_no_clear
      assign clr_en = 1'b0;
    end
  endgenerate

  always_comb begin
    upd_en  = evt | clr_en;
    cause_d = cause_q;
    if (evt)         cause_d = 1'b1;
    else if (clr_en) cause_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)    cause_q <= 1'b0;
    else if (upd_en) cause_q <= cause_d;
  end

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
    (cause_q && !clr_en) |=> cause_q);

  assert_evt_wins_R9: assert property (@(posedge clk) disable iff (!rst_n_i)
    evt |=> cause_q);

  generate
    if (CLR_KIND == CLR_WRITE) begin : g_chk_wr
      assert_write_clears_R3: assert property (@(posedge clk) disable iff (!rst_n_i)
        (cause_wr_clr && !evt) |=> !cause_q);
      assert_ignores_monrd_R10: assert property (@(posedge clk) disable iff (!rst_n_i)
        (cause_q && !cause_wr_clr) |=> cause_q);
    end else if (CLR_KIND == CLR_MONRD) begin : g_chk_rd
      assert_monrd_clears_R4: assert property (@(posedge clk) disable iff (!rst_n_i)
        (gpmon_rd && !evt) |=> !cause_q);
      assert_ignores_write_R4: assert property (@(posedge clk) disable iff (!rst_n_i)
        (cause_q && !gpmon_rd) |=> cause_q);
    end
  endgenerate
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n_i,
  input  logic               mask_wr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [CAUSE_W-1:0] mask_q
);
  logic [CAUSE_W-1:0] mask_d;

  always_comb begin
    mask_d = wdata[CAUSE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)     mask_q <= '0;
    else if (mask_wr) mask_q <= mask_d;
  end

  assert_mask_store_R6: assert property (@(posedge clk) disable iff (!rst_n_i)
    mask_wr |=> (mask_q == $past(wdata[CAUSE_W-1:0])));

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n_i)
    !mask_wr |=> $stable(mask_q));
endmodule

// File: rtl/irq_cause_mask.sv
module irq_cause_mask
  import irq_agg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CAUSE_ADDR = 8'h02,
  parameter logic [ADDR_W-1:0] MASK_ADDR  = 8'h03,
  parameter logic [ADDR_W-1:0] GPMON_ADDR = 8'h41,
  parameter int                SYNC_STG   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_rd,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [CAUSE_W-1:0] evt_pulse,
  output logic               irq_out
);
  logic               rst_n_i;
  logic               cause_wr_clr;
  logic               mask_wr;
  logic               gpmon_rd;
  logic [CAUSE_W-1:0] cause_q;
  logic [CAUSE_W-1:0] mask_q;
  logic [CAUSE_W-1:0] armed;

  irq_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_n_i)
  );

  irq_bus_decode #(
    .CAUSE_ADDR (CAUSE_ADDR),
    .MASK_ADDR  (MASK_ADDR),
    .GPMON_ADDR (GPMON_ADDR)
  ) u_decode (
    .clk          (clk),
    .rst_n_i      (rst_n_i),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .cause_q      (cause_q),
    .mask_q       (mask_q),
    .cause_wr_clr (cause_wr_clr),
    .mask_wr      (mask_wr),
    .gpmon_rd     (gpmon_rd),
    .bus_rdata    (bus_rdata)
  );

  generate
    for (genvar gi = 0; gi < CAUSE_W; gi++) begin : g_cause
      irq_cause_bit #(.CLR_KIND(clr_kind_of(gi))) u_bit (
        .clk          (clk),
        .rst_n_i      (rst_n_i),
        .evt          (evt_pulse[gi]),
        .cause_wr_clr (cause_wr_clr),
        .gpmon_rd     (gpmon_rd),
        .cause_q      (cause_q[gi])
      );
    end
  endgenerate

  irq_mask_reg u_mask (
    .clk     (clk),
    .rst_n_i (rst_n_i),
    .mask_wr (mask_wr),
    .wdata   (bus_wdata),
    .mask_q  (mask_q)
  );

  always_comb begin
    armed   = cause_q & mask_q;
    irq_out = |armed;
  end

  assert_irq_needs_mask_R7: assert property (@(posedge clk) disable iff (!rst_n_i)
    irq_out |-> (mask_q != '0));

  assert_irq_needs_cause_R7: assert property (@(posedge clk) disable iff (!rst_n_i)
    irq_out |-> (cause_q != '0));

  assert_unmasked_evt_irq_R8: assert property (@(posedge clk) disable iff (!rst_n_i)
    ((evt_pulse & mask_q) != '0 && !mask_wr) |=> irq_out);

  always_comb begin
    if (!rst_n_i) begin
      assert_reset_clear_R1: assert (cause_q == '0 && mask_q == '0);
    end
  end
endmodule

// File: tb/irq_cause_mask_bench.sv
module irq_cause_mask_bench;
  localparam int CLK_P = 10;
  localparam logic [7:0] A_CAUSE = 8'h02;
  localparam logic [7:0] A_MASK  = 8'h03;
  localparam logic [7:0] A_GPMON = 8'h41;

  typedef struct {
    string      tag;
    logic [7:0] rdata;
    logic       irq;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [5:0] evt_pulse = '0;
  logic       irq_out;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  logic [5:0] m_cause = '0;
  logic [5:0] m_mask  = '0;

  irq_cause_mask u_irq_cause_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .evt_pulse (evt_pulse),
    .irq_out   (irq_out)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] model_rd(input logic [7:0] a);
    if (a == A_CAUSE) return {2'b00, m_cause};
    if (a == A_MASK)  return {2'b00, m_mask};
    return 8'h00;
  endfunction

  task automatic read_chk(input logic [7:0] a, input string tag);
    exp_t e;
    @(negedge clk);
    e.tag = tag; e.rdata = model_rd(a); e.irq = |(m_cause & m_mask);
    exp_q.push_back(e);
    bus_addr = a; bus_rd = 1'b1;
    if (a == A_GPMON) m_cause[3] = evt_pulse[3];
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic write_op(input logic [7:0] a, input logic [7:0] d, input logic [5:0] ev);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; evt_pulse = ev;
    if (a == A_CAUSE) m_cause = m_cause & 6'b001000;
    if (a == A_MASK)  m_mask  = d[5:0];
    m_cause = m_cause | ev;
    @(negedge clk);
    bus_wr = 1'b0; evt_pulse = '0;
  endtask

  task automatic gpmon_read_evt(input logic [5:0] ev);
    exp_t e;
    @(negedge clk);
    e.tag = "R9 gpmon read rdata"; e.rdata = 8'h00; e.irq = |(m_cause & m_mask);
    exp_q.push_back(e);
    bus_addr = A_GPMON; bus_rd = 1'b1; evt_pulse = ev;
    m_cause[3] = 1'b0;
    m_cause = m_cause | ev;
    @(negedge clk);
    bus_rd = 1'b0; evt_pulse = '0;
  endtask

  task automatic pulse(input logic [5:0] ev);
    @(negedge clk);
    evt_pulse = ev;
    m_cause = m_cause | ev;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  // scoreboard monitor: samples before the edge that carries the read
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (bus_rd) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL monitor: read without expected item, rdata=%h expected none", bus_rdata);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          n_chk++;
          if (bus_rdata !== e.rdata) begin
            n_fail++;
            $display("FAIL %s: rdata actual=%h expected=%h", e.tag, bus_rdata, e.rdata);
          end
          n_chk++;
          if (irq_out !== e.irq) begin
            n_fail++;
            $display("FAIL %s (R7 irq): actual=%b expected=%b", e.tag, irq_out, e.irq);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    read_chk(A_CAUSE, "R1 cause after reset");
    read_chk(A_MASK,  "R1 mask after reset");
    // R2 R8 each bit sets with mask at 0
    for (int i = 0; i < 6; i++) begin
      pulse(6'b1 << i);
      read_chk(A_CAUSE, "R2 R8 single cause set");
    end
    repeat (10) @(negedge clk);
    read_chk(A_CAUSE, "R2 sticky after idle");
    // R10 reads do not clear
    read_chk(A_MASK,  "R10 mask read");
    read_chk(A_CAUSE, "R10 cause unchanged by reads");
    // R3 any write data clears, R4 gpio stays
    write_op(A_CAUSE, 8'h00, 6'b0);
    read_chk(A_CAUSE, "R3 R4 write 0x00 clears all but gpio");
    pulse(6'b110111);
    write_op(A_CAUSE, 8'hA5, 6'b0);
    read_chk(A_CAUSE, "R3 write 0xA5 clears");
    // R4 gpio cleared by monitor read
    read_chk(A_GPMON, "R4 R5 gpio monitor read");
    read_chk(A_CAUSE, "R4 gpio cleared by monitor read");
    // R6 mask write drops upper bits
    write_op(A_MASK, 8'hFF, 6'b0);
    read_chk(A_MASK, "R6 mask upper bits dropped");
    // R7 reporting
    read_chk(A_CAUSE, "R7 no cause no irq");
    pulse(6'b000001);
    read_chk(A_CAUSE, "R7 enabled cause raises irq");
    write_op(A_MASK, 8'h3E, 6'b0);
    read_chk(A_MASK, "R7 masked cause drops irq");
    pulse(6'b001000);
    read_chk(A_CAUSE, "R7 gpio enabled irq");
    write_op(A_CAUSE, 8'hFF, 6'b0);
    read_chk(A_CAUSE, "R4 gpio ignores write 0xFF");
    // R9 collisions
    write_op(A_CAUSE, 8'h00, 6'b000010);
    read_chk(A_CAUSE, "R9 event beats clearing write");
    gpmon_read_evt(6'b001000);
    read_chk(A_CAUSE, "R9 event beats monitor read");
    // R5 unmapped address
    read_chk(8'h7E, "R5 unmapped reads zero");
    write_op(A_MASK, 8'h00, 6'b0);
    read_chk(A_CAUSE, "R8 cause with mask zero, irq off");
    repeat (3) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: pending items actual=%0d expected=0", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule